// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that cannot be switched off. A counter advances on every pulse of a slow time-base tick. When it reaches the end of the selected period it wraps to zero and escalates. The first wrap after a clear produces a one-cycle non-maskable interrupt request and raises a warning flag. If software does not clear the watchdog before the next wrap, a reset request is raised. That request stays asserted until the synchronous reset input is applied.

Software chooses the period through a 3-bit select field and services the watchdog with a single-cycle kick strobe. The select value is sampled only on a kick or on reset, so a new period starts at a defined point. The parameter `TICK_MULT` scales every period by a whole factor, which lets a bench run fast ticks. All pins are plain control and status signals. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `wdog_escalate`

## Requirements
- R1: While `srst` is high, and in the first cycle after it falls, `nmi_pulse`, `rst_req` and `stage1_flag` are low. The counter is zero, and the period select is captured from `period_sel` during reset.
- R2: The period, measured in ticks, is TICK_MULT times a base value set by the captured select code: 0→6, 1→8, 2→16, 3→32, 4→128, 5→512, 6→2048, 7→2048 (ascending, with the last code equal to the longest period). An overflow occurs on the tick that completes the period, counted from the last clear or reset.
- R3: The first overflow after a clear drives `nmi_pulse` high for exactly one cycle, starting in the cycle after the completing tick. `stage1_flag` rises in the same cycle and stays high.
- R4: A second overflow with no kick since the first sets `rst_req` in the cycle after the completing tick. `rst_req` then stays high through any kicks, and only `srst` clears it.
- R5: A kick zeroes the counter and, unless `rst_req` is already set, returns the escalation state to idle, so `stage1_flag` is low from the next cycle. A kick wins over a tick in the same cycle, and that tick neither counts nor overflows.
- R6: A change on `period_sel` takes effect only at the next kick or reset. Until then the period captured earlier applies.
- R7: The counter has no stop control. It advances only on cycles where `tick` is high, so cycles without a tick do not shorten or extend the tick count to overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle time-base pulse that advances the counter |
| kick | input | 1 | One-cycle clear strobe from software |
| period_sel | input | 3 | Period select code, captured on kick or reset |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request on the first overflow |
| rst_req | output | 1 | Sticky reset request after the second overflow |
| stage1_flag | output | 1 | High once the first overflow has occurred and until a kick clears it |

## Verification
Some properties are checked on every cycle. The interrupt is never longer than one cycle and always appears together with the warning flag. A raised reset request stays high until reset. The counter never passes the end of its period, and it is zero after a kick. The captured select holds steady between kicks. Only the bench scenarios can show the exact tick count to overflow for each of the eight codes, and that a kick beats a tick arriving in the same cycle. The same holds for the delayed effect of a period change and the two-step escalation to reset. The bench covers these with directed runs and a long constrained-random run against a reference model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_SEL  = 1 << SEL_W;
  localparam int unsigned MAX_BASE = 2048;

  typedef enum logic [1:0] {
    ESC_IDLE   = 2'd0,
    ESC_WARNED = 2'd1,
    ESC_FIRED  = 2'd2
  } esc_state_t;

  // Base period in ticks for each select code, ascending; top code saturates.
  function automatic int unsigned base_ticks(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    base_ticks = 6;
      3'd1:    base_ticks = 8;
      3'd2:    base_ticks = 16;
      3'd3:    base_ticks = 32;
      3'd4:    base_ticks = 128;
      3'd5:    base_ticks = 512;
      default: base_ticks = MAX_BASE;
    endcase
  endfunction

endpackage

// File: rtl/wdog_period_latch.sv
module wdog_period_latch
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             srst,
  input  logic             kick,
  input  logic [SEL_W-1:0] sel_in,
  output logic [SEL_W-1:0] sel_q
);

  always_ff @(posedge clk) begin
    if (srst || kick) sel_q <= sel_in;
  end

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (srst)
    !kick |=> $stable(sel_q));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned TICK_MULT = 1,
  localparam int unsigned CNT_W    = $clog2(MAX_BASE * TICK_MULT)
)(
  input  logic             clk,
  input  logic             srst,
  input  logic             tick,
  input  logic             kick,
  input  logic [SEL_W-1:0] sel_q,
  output logic             ovf
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_tab [NUM_SEL];

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_last
    assign last_tab[g] = CNT_W'(base_ticks(SEL_W'(g)) * TICK_MULT - 1);
  end

  logic [CNT_W-1:0] last_val;
  assign last_val = last_tab[sel_q];
  assign ovf      = tick && !kick && (cnt == last_val);

  always_ff @(posedge clk) begin
    if (srst || kick)  cnt <= '0;
    else if (ovf)      cnt <= '0;
    else if (tick)     cnt <= cnt + 1'b1;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (srst)
    !kick |=> cnt <= last_tab[sel_q]);

  // R5
  kick_zero_chk: assert property (@(posedge clk) disable iff (srst)
    kick |=> cnt == '0);

  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (srst)
    (!tick && !kick) |=> $stable(cnt));

endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic srst,
  input  logic ovf,
  input  logic kick,
  output logic nmi_q,
  output logic rst_q,
  output logic warn
);

  esc_state_t state;

  always_ff @(posedge clk) begin
    if (srst) begin
      state <= ESC_IDLE;
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      nmi_q <= 1'b0;
      case (state)
        ESC_IDLE: begin
          if (ovf) begin
            nmi_q <= 1'b1;
            state <= ESC_WARNED;
          end
        end
        ESC_WARNED: begin
          if (kick) begin
            state <= ESC_IDLE;
          end else if (ovf) begin
            rst_q <= 1'b1;
            state <= ESC_FIRED;
          end
        end
        default: state <= ESC_FIRED;
      endcase
    end
  end

  assign warn = (state != ESC_IDLE);

  // R3
  nmi_single_chk: assert property (@(posedge clk) disable iff (srst)
    nmi_q |=> !nmi_q);

  // R3
  nmi_flag_chk: assert property (@(posedge clk) disable iff (srst)
    nmi_q |-> warn);

  // R4
  rst_sticky_chk: assert property (@(posedge clk) disable iff (srst)
    rst_q |=> rst_q);

  // R5
  kick_idle_chk: assert property (@(posedge clk) disable iff (srst)
    (kick && !rst_q) |=> !warn);

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdog_pkg::*;
#(
  parameter int unsigned TICK_MULT = 1
)(
  input  logic       clk,
  input  logic       srst,
  input  logic       tick,
  input  logic       kick,
  input  logic [2:0] period_sel,
  output logic       nmi_pulse,
  output logic       rst_req,
  output logic       stage1_flag
);

  logic [SEL_W-1:0] sel_q;
  logic             ovf;

  wdog_period_latch u_latch (
    .clk    (clk),
    .srst   (srst),
    .kick   (kick),
    .sel_in (period_sel),
    .sel_q  (sel_q)
  );

  wdog_counter #(.TICK_MULT(TICK_MULT)) u_cnt (
    .clk   (clk),
    .srst  (srst),
    .tick  (tick),
    .kick  (kick),
    .sel_q (sel_q),
    .ovf   (ovf)
  );

  wdog_escalator u_esc (
    .clk   (clk),
    .srst  (srst),
    .ovf   (ovf),
    .kick  (kick),
    .nmi_q (nmi_pulse),
    .rst_q (rst_req),
    .warn  (stage1_flag)
  );

  // R4
  rst_after_warn_chk: assert property (@(posedge clk) disable iff (srst)
    $rose(rst_req) |-> stage1_flag && !nmi_pulse);

endmodule

// File: tb/wdog_escalate_test.sv
module wdog_escalate_test;

  logic       clk = 1'b0;
  logic       srst = 1'b1;
  logic       tick = 1'b0;
  logic       kick = 1'b0;
  logic [2:0] period_sel = 3'd0;
  logic       nmi_pulse, rst_req, stage1_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int m_cnt = 0;
  int m_sel = 0;
  int m_st  = 0;
  bit m_nmi = 0;
  bit m_rst = 0;

  always #2 clk = ~clk;

  wdog_escalate uut (
    .clk(clk), .srst(srst), .tick(tick), .kick(kick),
    .period_sel(period_sel), .nmi_pulse(nmi_pulse),
    .rst_req(rst_req), .stage1_flag(stage1_flag)
  );

  function automatic int exp_ticks(input int code);
    case (code)
      0: return 6;
      1: return 8;
      2: return 16;
      3: return 32;
      4: return 128;
      5: return 512;
      default: return 2048;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_update(input bit t, input bit k, input int s, input bit r);
    bit ov;
    if (r) begin
      m_cnt = 0; m_sel = s; m_st = 0; m_nmi = 0; m_rst = 0;
    end else begin
      ov = t && !k && (m_cnt == exp_ticks(m_sel) - 1);
      if (k) m_sel = s;
      if (k || ov) m_cnt = 0;
      else if (t) m_cnt = m_cnt + 1;
      m_nmi = 0;
      if (m_st == 0 && ov) begin
        m_nmi = 1; m_st = 1;
      end else if (m_st == 1) begin
        if (k) m_st = 0;
        else if (ov) begin m_rst = 1; m_st = 2; end
      end
    end
  endtask

  // drive at negedge, clock once, compare at next negedge
  task automatic step(input bit t, input bit k, input int s, input bit r, input string tag);
    tick = t; kick = k; period_sel = 3'(s); srst = r;
    @(posedge clk);
    model_update(t, k, s, r);
    @(negedge clk);
    chk(nmi_pulse == m_nmi, {tag, " nmi"}, int'(nmi_pulse), int'(m_nmi));
    chk(rst_req == m_rst, {tag, " rst"}, int'(rst_req), int'(m_rst));
    chk(stage1_flag == (m_st != 0), {tag, " flag"}, int'(stage1_flag), int'(m_st != 0));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    int n;
    @(negedge clk);
    // R1: reset state
    step(0, 0, 0, 1, "R1");
    step(0, 0, 0, 1, "R1");
    chk(!nmi_pulse && !rst_req && !stage1_flag, "R1 outputs low in reset", int'(stage1_flag), 0);
    step(0, 0, 0, 0, "R1");

    // R2: ticks to first overflow for every code
    for (int code = 0; code < 8; code++) begin
      step(0, 0, code, 1, "R2");
      n = 0;
      do begin
        step(1, 0, code, 0, "R2");
        n++;
      end while (!nmi_pulse && n < 3000);
      chk(n == exp_ticks(code), "R2 ticks to overflow", n, exp_ticks(code));
      // R3: pulse lasts one cycle, flag stays
      step(0, 0, code, 0, "R3");
      chk(!nmi_pulse && stage1_flag, "R3 one-cycle pulse", int'(nmi_pulse), 0);
    end

    // R4: second overflow raises sticky reset request
    step(0, 0, 0, 1, "R4");
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, "R4");
    chk(rst_req == 1'b1, "R4 reset after second overflow", int'(rst_req), 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R4");
    chk(rst_req == 1'b1, "R4 reset held through kicks", int'(rst_req), 1);
    step(0, 0, 0, 1, "R4");
    chk(rst_req == 1'b0, "R4 cleared by srst", int'(rst_req), 0);

    // R6: new select ignored until a kick
    step(0, 0, 0, 1, "R6");
    for (int i = 0; i < 6; i++) step(1, 0, 6, 0, "R6");
    chk(nmi_pulse == 1'b1, "R6 old period still active", int'(nmi_pulse), 1);
    step(0, 1, 1, 0, "R6");
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0, "R6");
    chk(nmi_pulse == 1'b0, "R6 new period after kick", int'(nmi_pulse), 0);
    step(1, 0, 0, 0, "R6");
    chk(nmi_pulse == 1'b1, "R6 overflow at 8 ticks", int'(nmi_pulse), 1);

    // R5: kick clears flag; kick beats a simultaneous tick
    step(0, 1, 0, 0, "R5");
    chk(stage1_flag == 1'b0, "R5 kick clears flag", int'(stage1_flag), 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R5");
    step(1, 1, 0, 0, "R5");
    chk(nmi_pulse == 1'b0, "R5 kick wins over tick", int'(nmi_pulse), 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R5");
    chk(nmi_pulse == 1'b0, "R5 counter restarted", int'(nmi_pulse), 0);
    step(1, 0, 0, 0, "R5");
    chk(nmi_pulse == 1'b1, "R5 overflow after full period", int'(nmi_pulse), 1);

    // R7: idle cycles between ticks do not change the tick count
    step(0, 1, 0, 0, "R7");
    for (int i = 0; i < 5; i++) begin
      step(1, 0, 0, 0, "R7");
      for (int j = 0; j < 7; j++) step(0, 0, 0, 0, "R7");
    end
    chk(nmi_pulse == 1'b0 && stage1_flag == 1'b0, "R7 no overflow yet", int'(stage1_flag), 0);
    step(1, 0, 0, 0, "R7");
    chk(nmi_pulse == 1'b1, "R7 overflow on sixth tick", int'(nmi_pulse), 1);

    // constrained random against the model (R2..R7)
    void'($urandom(32'd1234));
    step(0, 0, 0, 1, "RND R1");
    for (int i = 0; i < 20000; i++) begin
      bit t, k, r;
      int s;
      t = ($urandom % 4) != 0;
      k = ($urandom % 48) == 0;
      r = ($urandom % 5000) == 0;
      s = ($urandom % 100) < 70 ? ($urandom % 3) : ($urandom % 8);
      step(t, k, s, r, "RND R2");
    end

    finish_run();
  end

endmodule